// File: doc/BRIEF.md
# Shared-Bus Clock Register Interface

This block is the slave end of a clock chip whose host reaches it over a single 8-bit bus that carries both the register number and the data. The host first drives a register number while an address strobe is high, and the block takes that number when the strobe falls. The host then pulses a data strobe one or more times. Each pulse either drives the addressed byte out or stores the byte on the bus. Every bus line is sampled on the block clock, so each strobe must stay in one state for at least three clock cycles.

Behind the bus is a 64-byte space. Offsets 0 to 9 hold the time and alarm fields, offsets 10 to 13 hold four control and status registers, and offsets 14 to 63 hold general-purpose RAM. The timekeeping unit reads the time fields through a flat output and writes them through a separate update port. That port is locked out while the freeze bit (offset 11, bit 7) is set. The interrupt unit supplies the flag nibble shown at offset 12 and receives a one-cycle pulse after each completed read of that offset, so it can clear its flags once the host has them.

Top module: `rtc_mux_bus_if`

## Requirements
- R1: On a falling address strobe with chip enable high, the low 6 bits of the bus are taken as the register offset, so offset 84 selects 20. The offset is kept across any number of data strobes until the next address strobe.
- R2: A write strobe (rd low) stores the bus byte in the latched offset when the strobe ends. Repeated strobes without a new address all target the same offset, and the last one wins.
- R3: During a read strobe, `bus_oe` is high and `bus_dout` holds one unchanging copy of the addressed byte for the whole strobe. With no read active, `bus_oe` is low and `bus_dout` is 0.
- R4: A data strobe that rises while chip enable is low causes no access: nothing is stored and nothing is driven. An address strobe with chip enable low leaves the latched offset unchanged.
- R5: Offset 12 reads as {flags_in[3:0], 4'b0000}. Each completed read of it raises `rdc_pulse` for exactly one cycle after the strobe ends. Writes to offset 12 have no effect and raise no pulse.
- R6: At offset 10, bit 7 always reads as `uip_in` and host writes to that bit are discarded. Bits 6:0 are read/write and appear on `ctrl_a_out`.
- R7: Offset 11 is read/write and appears on `ctrl_b_out`. While its bit 7 is 1, `time_freeze` is high and the update port writes nothing, but host writes to the time fields still land.
- R8: Offset 13 reads as {vrt_in, 7'b0} and host writes to it are discarded.
- R9: When a host write and an update-port write reach the same time field in the same cycle, the host value is kept. When they reach different fields, both land.
- R10: If chip enable drops while a data strobe is active, the access is abandoned: a pending write is discarded and no clear pulse is raised.
- R11: After reset, all stored bytes, the latched offset, `bus_oe`, `bus_dout` and `rdc_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce | input | 1 | Chip enable, active high |
| bus_as | input | 1 | Address strobe, offset latched on its falling edge |
| bus_ds | input | 1 | Data strobe, one access per high pulse |
| bus_rd | input | 1 | Direction, 1 = read, 0 = write, set before the data strobe rises |
| bus_din | input | 8 | Shared bus, incoming address or data |
| bus_dout | output | 8 | Read data, 0 when not driving |
| bus_oe | output | 1 | High while read data is driven |
| flags_in | input | 4 | Interrupt flag nibble from the interrupt unit |
| uip_in | input | 1 | Update-in-progress status from the timekeeping unit |
| vrt_in | input | 1 | Supply-valid status |
| rdc_pulse | output | 1 | One-cycle pulse after a completed read of offset 12 |
| upd_we | input | 1 | Update-port write enable |
| upd_idx | input | 4 | Update-port time field index, 0 to 9 |
| upd_data | input | 8 | Update-port data |
| time_out | output | 80 | Time fields 0 to 9, field i in bits 8i+7:8i |
| ctrl_a_out | output | 7 | Bits 6:0 of offset 10 |
| ctrl_b_out | output | 8 | Offset 11 |
| time_freeze | output | 1 | High while offset 11 bit 7 is set |

## Verification
Two functions can fall in the same cycle: a host write ending on a time field, and the timekeeping unit's update port writing a field. The bench lowers the data strobe and then, counting the two register stages on the strobe path, raises `upd_we` so that it lands on the exact edge where the host write commits. It does this once with both writes aimed at the seconds field and once with them aimed at different fields. The results are read back over the bus: the host value must survive in the first case, and both values must be present in the second.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
  localparam int BUS_W    = 8;
  localparam int SPACE    = 64;
  localparam int ADDR_W   = $clog2(SPACE);
  localparam int N_TIME   = 10;
  localparam int IDX_W    = $clog2(N_TIME);
  localparam int OFF_A    = 10;
  localparam int OFF_B    = 11;
  localparam int OFF_C    = 12;
  localparam int OFF_D    = 13;
  localparam int RAM_BASE = 14;
  localparam int RAM_N    = SPACE - RAM_BASE;
  localparam int FLAG_W   = 4;

  typedef logic [BUS_W-1:0]  byte_t;
  typedef logic [ADDR_W-1:0] off_t;
endpackage

// File: rtl/rtc_bus_sample.sv
module rtc_bus_sample
  import rtc_bus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_i,
  input  logic  as_i,
  input  logic  ds_i,
  input  logic  rd_i,
  input  byte_t din_i,
  output logic  ce_o,
  output logic  rd_o,
  output logic  as_fall_o,
  output logic  ds_rise_o,
  output logic  ds_fall_o,
  output byte_t din_o
);
  logic  ce_s, as_s, ds_s, rd_s, as_p, ds_p;
  byte_t din_s, din_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_s  <= 1'b0;
      as_s  <= 1'b0;
      ds_s  <= 1'b0;
      rd_s  <= 1'b0;
      din_s <= '0;
      as_p  <= 1'b0;
      ds_p  <= 1'b0;
      din_p <= '0;
    end else begin
      ce_s  <= ce_i;
      as_s  <= as_i;
      ds_s  <= ds_i;
      rd_s  <= rd_i;
      din_s <= din_i;
      as_p  <= as_s;
      ds_p  <= ds_s;
      din_p <= din_s;
    end
  end

  assign ce_o      = ce_s;
  assign rd_o      = rd_s;
  assign as_fall_o = as_p & ~as_s & ce_s;
  assign ds_rise_o = ds_s & ~ds_p & ce_s;
  assign ds_fall_o = ds_p & ~ds_s;
  assign din_o     = din_p;
endmodule

// File: rtl/rtc_bus_ctrl.sv
module rtc_bus_ctrl
  import rtc_bus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_i,
  input  logic  rd_i,
  input  logic  as_fall_i,
  input  logic  ds_rise_i,
  input  logic  ds_fall_i,
  input  byte_t din_i,
  input  byte_t rd_data_i,
  output off_t  addr_o,
  output logic  wr_en_o,
  output byte_t wr_data_o,
  output byte_t dout_o,
  output logic  oe_o,
  output logic  rdc_o
);
  off_t  addr_q, addr_d;
  logic  act_q, act_d, dir_q, dir_d, rdc_q, rdc_d;
  byte_t hold_q, hold_d;
  logic  finish, abort;

  assign abort  = act_q & ~ce_i;
  assign finish = act_q & ce_i & ds_fall_i;

  always_comb begin
    addr_d = addr_q;
    act_d  = act_q;
    dir_d  = dir_q;
    hold_d = hold_q;
    rdc_d  = 1'b0;
    if (as_fall_i) addr_d = din_i[ADDR_W-1:0];
    if (abort || finish) begin
      act_d = 1'b0;
      rdc_d = finish & dir_q & (addr_q == off_t'(OFF_C));
    end else if (!act_q && ds_rise_i) begin
      act_d  = 1'b1;
      dir_d  = rd_i;
      hold_d = rd_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      act_q  <= 1'b0;
      dir_q  <= 1'b0;
      hold_q <= '0;
      rdc_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      act_q  <= act_d;
      dir_q  <= dir_d;
      hold_q <= hold_d;
      rdc_q  <= rdc_d;
    end
  end

  assign addr_o    = addr_q;
  assign wr_en_o   = finish & ~dir_q;
  assign wr_data_o = din_i;
  assign oe_o      = act_q & dir_q;
  assign dout_o    = oe_o ? hold_q : '0;
  assign rdc_o     = rdc_q;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_bus_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  off_t                    addr_i,
  input  byte_t                   wr_data_i,
  input  logic                    upd_we_i,
  input  logic [IDX_W-1:0]        upd_idx_i,
  input  byte_t                   upd_data_i,
  input  logic [FLAG_W-1:0]       flags_i,
  input  logic                    uip_i,
  input  logic                    vrt_i,
  output byte_t                   rd_data_o,
  output logic [N_TIME*BUS_W-1:0] time_o,
  output logic [BUS_W-2:0]        ctrl_a_o,
  output byte_t                   ctrl_b_o
);
  byte_t            tf_q  [N_TIME];
  byte_t            ram_q [RAM_N];
  logic [BUS_W-2:0] a_q;
  byte_t            b_q;
  logic             freeze;

  assign freeze = b_q[BUS_W-1];

  for (genvar i = 0; i < N_TIME; i++) begin : g_time
    logic  host_hit, upd_hit, en;
    byte_t nxt;
    always_comb begin
      host_hit = wr_en_i & (addr_i == off_t'(i));
      upd_hit  = upd_we_i & ~freeze & (upd_idx_i == IDX_W'(i));
      en       = host_hit | upd_hit;
      nxt      = host_hit ? wr_data_i : upd_data_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tf_q[i] <= '0;
      else if (en) tf_q[i] <= nxt;
    end
    assign time_o[i*BUS_W +: BUS_W] = tf_q[i];
  end

  for (genvar j = 0; j < RAM_N; j++) begin : g_ram
    logic en;
    assign en = wr_en_i & (addr_i == off_t'(RAM_BASE + j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ram_q[j] <= '0;
      else if (en) ram_q[j] <= wr_data_i;
    end
  end

  logic a_en, b_en;
  assign a_en = wr_en_i & (addr_i == off_t'(OFF_A));
  assign b_en = wr_en_i & (addr_i == off_t'(OFF_B));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_en) a_q <= wr_data_i[BUS_W-2:0];
      if (b_en) b_q <= wr_data_i;
    end
  end

  always_comb begin
    if (addr_i < off_t'(N_TIME))       rd_data_o = tf_q[IDX_W'(addr_i)];
    else if (addr_i == off_t'(OFF_A))  rd_data_o = {uip_i, a_q};
    else if (addr_i == off_t'(OFF_B))  rd_data_o = b_q;
    else if (addr_i == off_t'(OFF_C))  rd_data_o = {flags_i, {(BUS_W-FLAG_W){1'b0}}};
    else if (addr_i == off_t'(OFF_D))  rd_data_o = {vrt_i, {(BUS_W-1){1'b0}}};
    else                               rd_data_o = ram_q[addr_i - off_t'(RAM_BASE)];
  end

  assign ctrl_a_o = a_q;
  assign ctrl_b_o = b_q;
endmodule

// File: rtl/rtc_mux_bus_if.sv
module rtc_mux_bus_if
  import rtc_bus_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_ce,
  input  logic                    bus_as,
  input  logic                    bus_ds,
  input  logic                    bus_rd,
  input  logic [7:0]              bus_din,
  output logic [7:0]              bus_dout,
  output logic                    bus_oe,
  input  logic [3:0]              flags_in,
  input  logic                    uip_in,
  input  logic                    vrt_in,
  output logic                    rdc_pulse,
  input  logic                    upd_we,
  input  logic [3:0]              upd_idx,
  input  logic [7:0]              upd_data,
  output logic [79:0]             time_out,
  output logic [6:0]              ctrl_a_out,
  output logic [7:0]              ctrl_b_out,
  output logic                    time_freeze
);
  logic  ce_s, rd_s, as_fall, ds_rise, ds_fall, wr_en;
  byte_t din_p, wr_data, rd_data;
  off_t  addr;

  rtc_bus_sample u_sample (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_i      (bus_ce),
    .as_i      (bus_as),
    .ds_i      (bus_ds),
    .rd_i      (bus_rd),
    .din_i     (bus_din),
    .ce_o      (ce_s),
    .rd_o      (rd_s),
    .as_fall_o (as_fall),
    .ds_rise_o (ds_rise),
    .ds_fall_o (ds_fall),
    .din_o     (din_p)
  );

  rtc_bus_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_i      (ce_s),
    .rd_i      (rd_s),
    .as_fall_i (as_fall),
    .ds_rise_i (ds_rise),
    .ds_fall_i (ds_fall),
    .din_i     (din_p),
    .rd_data_i (rd_data),
    .addr_o    (addr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .dout_o    (bus_dout),
    .oe_o      (bus_oe),
    .rdc_o     (rdc_pulse)
  );

  rtc_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wr_data_i  (wr_data),
    .upd_we_i   (upd_we),
    .upd_idx_i  (upd_idx),
    .upd_data_i (upd_data),
    .flags_i    (flags_in),
    .uip_i      (uip_in),
    .vrt_i      (vrt_in),
    .rd_data_o  (rd_data),
    .time_o     (time_out),
    .ctrl_a_o   (ctrl_a_out),
    .ctrl_b_o   (ctrl_b_out)
  );

  assign time_freeze = ctrl_b_out[7];
endmodule

// File: rtl/rtc_mux_bus_if_chk.sv
module rtc_mux_bus_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_ce,
  input logic [7:0]  bus_dout,
  input logic        bus_oe,
  input logic        rdc_pulse,
  input logic [79:0] time_out,
  input logic        time_freeze
);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_dout == 8'h00);

  p_drive_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe && $past(bus_oe) |-> $stable(bus_dout));

  p_drive_needs_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(bus_ce, 2));

  p_clear_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdc_pulse |=> !rdc_pulse);

  p_clear_after_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdc_pulse |-> !bus_oe);

  p_frozen_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    time_freeze && !bus_ce |=> $stable(time_out));
endmodule

bind rtc_mux_bus_if rtc_mux_bus_if_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_ce      (bus_ce),
  .bus_dout    (bus_dout),
  .bus_oe      (bus_oe),
  .rdc_pulse   (rdc_pulse),
  .time_out    (time_out),
  .time_freeze (time_freeze)
);

// File: tb/rtc_mux_bus_if_tb.sv
module rtc_mux_bus_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_ce = 1'b0, bus_as = 1'b0, bus_ds = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_din = 8'h00;
  logic [7:0]  bus_dout;
  logic        bus_oe, rdc_pulse, time_freeze;
  logic [3:0]  flags_in = 4'h0;
  logic        uip_in = 1'b0, vrt_in = 1'b0;
  logic        upd_we = 1'b0;
  logic [3:0]  upd_idx = 4'h0;
  logic [7:0]  upd_data = 8'h00;
  logic [79:0] time_out;
  logic [6:0]  ctrl_a_out;
  logic [7:0]  ctrl_b_out;

  int total = 0;
  int bad = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  rtc_mux_bus_if u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_as(bus_as), .bus_ds(bus_ds),
    .bus_rd(bus_rd), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .flags_in(flags_in), .uip_in(uip_in), .vrt_in(vrt_in), .rdc_pulse(rdc_pulse),
    .upd_we(upd_we), .upd_idx(upd_idx), .upd_data(upd_data), .time_out(time_out),
    .ctrl_a_out(ctrl_a_out), .ctrl_b_out(ctrl_b_out), .time_freeze(time_freeze)
  );

  always @(posedge clk) if (rdc_pulse) pulses <= pulses + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(input logic [7:0] a, input logic ce);
    @(negedge clk);
    bus_ce = ce; bus_as = 1'b1; bus_din = a;
    idle(4);
    bus_as = 1'b0;
    idle(4);
    bus_ce = 1'b0; bus_din = 8'h00;
    idle(1);
  endtask

  task automatic wr_strobe(input logic [7:0] d, input logic ce);
    @(negedge clk);
    bus_ce = ce; bus_rd = 1'b0; bus_din = d; bus_ds = 1'b1;
    idle(4);
    bus_ds = 1'b0;
    idle(4);
    bus_ce = 1'b0; bus_din = 8'h00;
    idle(1);
  endtask

  task automatic rd_strobe(output logic [7:0] d, output logic oe_seen, output logic steady);
    logic [7:0] first;
    @(negedge clk);
    bus_ce = 1'b1; bus_rd = 1'b1; bus_ds = 1'b1;
    idle(4);
    oe_seen = bus_oe;
    first = bus_dout;
    idle(2);
    steady = (bus_dout == first) && bus_oe;
    d = first;
    bus_ds = 1'b0;
    idle(4);
    bus_ce = 1'b0; bus_rd = 1'b0;
    idle(1);
  endtask

  task automatic wr_at(input logic [7:0] a, input logic [7:0] d);
    set_addr(a, 1'b1);
    wr_strobe(d, 1'b1);
  endtask

  task automatic rd_at(input logic [7:0] a, output logic [7:0] d);
    logic oe_seen, steady;
    set_addr(a, 1'b1);
    rd_strobe(d, oe_seen, steady);
  endtask

  task automatic t_reset;
    chk("R11 oe", 32'(bus_oe), 0);
    chk("R11 dout", 32'(bus_dout), 0);
    chk("R11 rdc", 32'(rdc_pulse), 0);
    chk("R11 time", 32'(time_out[31:0] | time_out[63:32] | 32'(time_out[79:64])), 0);
    chk("R11 ctrl_b", 32'(ctrl_b_out), 0);
  endtask

  task automatic t_ram;
    logic [7:0] d;
    logic oe_seen, steady;
    wr_at(8'd14, 8'h5A);
    wr_at(8'd63, 8'hC3);
    set_addr(8'd14, 1'b1);
    rd_strobe(d, oe_seen, steady);
    chk("R2 ram14", 32'(d), 32'h5A);
    chk("R3 oe high", 32'(oe_seen), 1);
    chk("R3 dout steady", 32'(steady), 1);
    chk("R3 oe idle", 32'(bus_oe), 0);
    chk("R3 dout idle", 32'(bus_dout), 0);
    rd_at(8'd63, d);
    chk("R2 ram63", 32'(d), 32'hC3);
    wr_at(8'd84, 8'h77);
    rd_at(8'd20, d);
    chk("R1 wrap", 32'(d), 32'h77);
    set_addr(8'd30, 1'b1);
    wr_strobe(8'h11, 1'b1);
    wr_strobe(8'h22, 1'b1);
    rd_strobe(d, oe_seen, steady);
    chk("R1 R2 held offset", 32'(d), 32'h22);
  endtask

  task automatic t_phantom;
    logic [7:0] d;
    logic oe_seen, steady;
    wr_at(8'd15, 8'hAA);
    set_addr(8'd15, 1'b1);
    wr_strobe(8'h55, 1'b0);
    rd_strobe(d, oe_seen, steady);
    chk("R4 no ce write", 32'(d), 32'hAA);
    set_addr(8'd16, 1'b0);
    rd_strobe(d, oe_seen, steady);
    chk("R4 no ce address", 32'(d), 32'hAA);
    @(negedge clk);
    bus_rd = 1'b1; bus_ds = 1'b1;
    idle(3);
    bus_ce = 1'b1;
    idle(4);
    chk("R4 late ce no drive", 32'(bus_oe), 0);
    bus_ds = 1'b0;
    idle(3);
    bus_ce = 1'b0; bus_rd = 1'b0;
    idle(1);
  endtask

  task automatic t_regc;
    logic [7:0] d;
    int p0;
    flags_in = 4'hB;
    p0 = pulses;
    rd_at(8'd12, d);
    chk("R5 read flags", 32'(d), 32'hB0);
    chk("R5 one pulse", 32'(pulses - p0), 1);
    p0 = pulses;
    wr_at(8'd12, 8'hFF);
    chk("R5 write no pulse", 32'(pulses - p0), 0);
    flags_in = 4'h0;
    rd_at(8'd12, d);
    chk("R5 write ignored", 32'(d), 32'h00);
  endtask

  task automatic t_rega;
    logic [7:0] d;
    uip_in = 1'b0;
    wr_at(8'd10, 8'hFF);
    rd_at(8'd10, d);
    chk("R6 bit7 discarded", 32'(d), 32'h7F);
    chk("R6 ctrl_a", 32'(ctrl_a_out), 32'h7F);
    uip_in = 1'b1;
    rd_at(8'd10, d);
    chk("R6 uip shown", 32'(d), 32'hFF);
    uip_in = 1'b0;
  endtask

  task automatic upd_write(input logic [3:0] i, input logic [7:0] v);
    @(negedge clk);
    upd_we = 1'b1; upd_idx = i; upd_data = v;
    @(negedge clk);
    upd_we = 1'b0;
  endtask

  task automatic t_freeze;
    logic [7:0] d;
    wr_at(8'd11, 8'h80);
    chk("R7 freeze out", 32'(time_freeze), 1);
    chk("R7 ctrl_b", 32'(ctrl_b_out), 32'h80);
    upd_write(4'd0, 8'h59);
    chk("R7 update blocked", 32'(time_out[7:0]), 0);
    wr_at(8'd0, 8'h12);
    rd_at(8'd0, d);
    chk("R7 host lands", 32'(d), 32'h12);
    wr_at(8'd11, 8'h00);
    upd_write(4'd2, 8'h34);
    chk("R7 update after unfreeze", 32'(time_out[23:16]), 32'h34);
    rd_at(8'd2, d);
    chk("R7 update read", 32'(d), 32'h34);
  endtask

  task automatic t_regd;
    logic [7:0] d;
    vrt_in = 1'b1;
    rd_at(8'd13, d);
    chk("R8 vrt shown", 32'(d), 32'h80);
    wr_at(8'd13, 8'h00);
    rd_at(8'd13, d);
    chk("R8 write ignored", 32'(d), 32'h80);
    vrt_in = 1'b0;
    rd_at(8'd13, d);
    chk("R8 vrt low", 32'(d), 32'h00);
  endtask

  task automatic collide(input logic [7:0] a, input logic [7:0] hv,
                         input logic [3:0] ui, input logic [7:0] uv);
    set_addr(a, 1'b1);
    @(negedge clk);
    bus_ce = 1'b1; bus_rd = 1'b0; bus_din = hv; bus_ds = 1'b1;
    idle(4);
    bus_ds = 1'b0;
    @(negedge clk);
    upd_we = 1'b1; upd_idx = ui; upd_data = uv;
    @(negedge clk);
    upd_we = 1'b0;
    idle(3);
    bus_ce = 1'b0; bus_din = 8'h00;
    idle(1);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    collide(8'd0, 8'h30, 4'd0, 8'h45);
    rd_at(8'd0, d);
    chk("R9 host wins", 32'(d), 32'h30);
    collide(8'd4, 8'h08, 4'd2, 8'h21);
    rd_at(8'd4, d);
    chk("R9 host other field", 32'(d), 32'h08);
    rd_at(8'd2, d);
    chk("R9 update other field", 32'(d), 32'h21);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    int p0;
    wr_at(8'd40, 8'h66);
    set_addr(8'd40, 1'b1);
    @(negedge clk);
    bus_ce = 1'b1; bus_rd = 1'b0; bus_din = 8'h99; bus_ds = 1'b1;
    idle(3);
    bus_ce = 1'b0;
    idle(3);
    bus_ds = 1'b0;
    idle(3);
    rd_at(8'd40, d);
    chk("R10 write dropped", 32'(d), 32'h66);
    flags_in = 4'h5;
    p0 = pulses;
    set_addr(8'd12, 1'b1);
    @(negedge clk);
    bus_ce = 1'b1; bus_rd = 1'b1; bus_ds = 1'b1;
    idle(4);
    bus_ce = 1'b0;
    idle(3);
    bus_ds = 1'b0; bus_rd = 1'b0;
    idle(3);
    chk("R10 no pulse", 32'(pulses - p0), 0);
    flags_in = 4'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R11 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(3);
    t_reset;
    t_ram;
    t_phantom;
    t_regc;
    t_rega;
    t_freeze;
    t_regd;
    t_collide;
    t_abort;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule